// File: doc/BRIEF.md
# SMBus Host Controller Engine

This block lets a processor run SMBus transactions through a small byte-wide register window. Software loads a target address with a direction bit, a command byte and up to two data bytes, or fills a 32-entry block buffer. It then writes a protocol code together with a go bit. The block walks the chosen protocol by handing one byte-level operation at a time (start, write byte, read byte with ACK or NACK, stop) to a lower byte engine. The byte engine owns the bit timing and reports back per operation.

On completion the block clears its busy flag and sets either a success flag or one of three error flags. Each of these flags clears when software writes a one to it. Received bytes land in the data registers or in the block buffer. Software reads the buffer back through a single sequential port, and reading the control register rewinds that port's pointer.

The byte engine handshake works as follows. `be_req` is held high with a stable `be_op`, `be_tx` and `be_nack` until the engine pulses `be_done` for one cycle. In that cycle `be_ack`, `be_arb_lost` and `be_rx` carry the result. Operation codes are 0 start (also used for repeated start), 1 write byte, 2 read byte and 3 stop.

Top module: `smbus_host`

## Requirements
- R1: After reset every register offset reads 0, `irq` is low and `be_req` is low.
- R2: A control write with bit 6 set and a valid protocol in bits 4:2 sets busy (status bit 0) and begins with a start operation. While busy, writes to offsets 2 to 7 have no effect, so a second go request is ignored.
- R3: Protocol 000 (quick) issues start, the address byte {addr[7:1], addr[0]}, then stop.
- R4: Protocol 001 (byte) writes the command register as its only data byte when addr[0]=0. When addr[0]=1 it reads one byte with NACK into data 0 (offset 5). In both cases it ends with stop.
- R5: Protocols 010 (byte data) and 011 (word data) with addr[0]=0 send the address with bit 0 cleared, then the command byte, then data 0, then (for word) data 1, then stop.
- R6: The same protocols with addr[0]=1 send the address with write bit, the command, a repeated start and the address with bit 0 set. They then read one byte (byte data) or two bytes (word, low byte into data 0 and high into data 1). Every byte is ACKed except the last, which is NACKed, and a stop follows.
- R7: Protocol 101 (block) with addr[0]=0 sends min(data 0, 32) as the count byte. It then sends that many bytes from buffer entry 0 upward, then stop.
- R8: Protocol 101 with addr[0]=1 ACKs the first received byte and stores min(byte, 32) in data 0. It then reads that many bytes into buffer entries 0 upward, NACKing the last, then stops. A count of zero goes straight to stop.
- R9: Each write or read at offset 7 accesses the buffer entry at the pointer and then advances it. Any read of offset 2 returns the pointer to entry 0.
- R10: A write operation completed without ACK ends the transaction: a stop follows, no further byte is sent, busy clears and status bit 2 is set.
- R11: An arbitration-lost result sets status bit 3, clears busy and issues no further operation.
- R12: A go request with protocol 100, 110 or 111 sets status bit 4, issues no operation and leaves busy clear.
- R13: A successful transaction sets status bit 1. Writing 1 to status bits 1 to 4 clears them and writing 0 leaves them. If a flag is set in the same cycle as a clear, the set wins.
- R14: `irq` equals control bit 0 ANDed with the OR of status bits 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on offsets 2 and 7) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| be_req | output | 1 | Byte operation request |
| be_op | output | 2 | Operation code |
| be_tx | output | 8 | Byte to transmit |
| be_nack | output | 1 | NACK the byte being read |
| be_done | input | 1 | Operation complete pulse |
| be_ack | input | 1 | Target ACKed the written byte |
| be_arb_lost | input | 1 | Arbitration lost during operation |
| be_rx | input | 8 | Received byte |

## Verification
Two things can act on the status register in the same cycle: the engine setting the success flag as the final stop completes, and a software write-one-to-clear. The bench watches for the cycle in which `be_done` is high on the stop operation. It drives a status write of 0x1E into exactly that edge, then reads status back. The success bit must still be set and busy clear, which shows that the new completion was not swallowed by the clear.

// File: rtl/smbus_host.sv
module smbus_host #(
  parameter int BLK_MAX = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       be_req,
  output logic [1:0] be_op,
  output logic [7:0] be_tx,
  output logic       be_nack,
  input  logic       be_done,
  input  logic       be_ack,
  input  logic       be_arb_lost,
  input  logic [7:0] be_rx
);
  localparam int PW = $clog2(BLK_MAX);
  localparam int CW = $clog2(BLK_MAX + 2);
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;
  localparam logic [2:0] PR_QUICK = 3'd0, PR_BYTE = 3'd1, PR_BDATA = 3'd2, PR_WDATA = 3'd3, PR_BLOCK = 3'd5;

  typedef enum logic [3:0] {S_IDLE, S_START, S_ADDR, S_CMD, S_RSTART, S_RADDR, S_WDATA, S_RDATA, S_STOP} state_t;

  state_t        state;
  logic          ien;
  logic [2:0]    proto;
  logic [7:0]    cmd_r, addr_r, dat0, dat1;
  logic [7:0]    blk_mem [BLK_MAX];
  logic [PW-1:0] bptr;
  logic [CW-1:0] idx;
  logic          st_done, st_nr, st_col, st_fail, nr_pend;

  logic          busy, rd, is_blk, two_phase, last, go_ok;
  logic [CW-1:0] blk_cnt, rx_cnt, nbytes;
  logic [PW-1:0] bidx;
  logic [7:0]    wbyte;

  assign busy      = state != S_IDLE;
  assign rd        = addr_r[0];
  assign is_blk    = proto == PR_BLOCK;
  assign two_phase = rd && proto != PR_QUICK && proto != PR_BYTE;
  assign blk_cnt   = (dat0 > 8'(BLK_MAX)) ? CW'(BLK_MAX) : dat0[CW-1:0];
  assign rx_cnt    = (be_rx > 8'(BLK_MAX)) ? CW'(BLK_MAX) : be_rx[CW-1:0];
  assign bidx      = PW'(idx - CW'(1));
  assign last      = idx == nbytes - CW'(1);
  assign go_ok     = reg_wdata[4:2] inside {PR_QUICK, PR_BYTE, PR_BDATA, PR_WDATA, PR_BLOCK};

  always_comb begin
    case (proto)
      PR_BYTE, PR_BDATA: nbytes = CW'(1);
      PR_WDATA:          nbytes = CW'(2);
      PR_BLOCK:          nbytes = blk_cnt + CW'(1);
      default:           nbytes = '0;
    endcase
  end

  assign wbyte = (idx == '0) ? (is_blk ? 8'(blk_cnt) : dat0)
                             : (is_blk ? blk_mem[bidx] : dat1);

  assign be_req  = busy;
  assign be_nack = state == S_RDATA && !(is_blk && idx == '0) && last;

  always_comb begin
    be_op = OP_WRITE;
    be_tx = 8'h00;
    case (state)
      S_START, S_RSTART: be_op = OP_START;
      S_ADDR:  be_tx = {addr_r[7:1], two_phase ? 1'b0 : rd};
      S_RADDR: be_tx = {addr_r[7:1], 1'b1};
      S_CMD:   be_tx = cmd_r;
      S_WDATA: be_tx = wbyte;
      S_RDATA: be_op = OP_READ;
      S_STOP:  be_op = OP_STOP;
      default: be_op = OP_WRITE;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {3'b000, st_fail, st_col, st_nr, st_done, busy};
      3'd2:    reg_rdata = {3'b000, proto, 1'b0, ien};
      3'd3:    reg_rdata = cmd_r;
      3'd4:    reg_rdata = addr_r;
      3'd5:    reg_rdata = dat0;
      3'd6:    reg_rdata = dat1;
      3'd7:    reg_rdata = blk_mem[bptr];
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = ien & (st_done | st_nr | st_col | st_fail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ien     <= 1'b0;
      proto   <= '0;
      cmd_r   <= '0;
      addr_r  <= '0;
      dat0    <= '0;
      dat1    <= '0;
      bptr    <= '0;
      idx     <= '0;
      st_done <= 1'b0;
      st_nr   <= 1'b0;
      st_col  <= 1'b0;
      st_fail <= 1'b0;
      nr_pend <= 1'b0;
      for (int i = 0; i < BLK_MAX; i++) blk_mem[i] <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd0) begin
        if (reg_wdata[1]) st_done <= 1'b0;
        if (reg_wdata[2]) st_nr   <= 1'b0;
        if (reg_wdata[3]) st_col  <= 1'b0;
        if (reg_wdata[4]) st_fail <= 1'b0;
      end
      if (reg_rd && reg_addr == 3'd7) bptr <= bptr + PW'(1);
      if (reg_rd && reg_addr == 3'd2) bptr <= '0;
      if (reg_wr && !busy) begin
        case (reg_addr)
          3'd2: begin
            ien   <= reg_wdata[0];
            proto <= reg_wdata[4:2];
            if (reg_wdata[6]) begin
              if (go_ok) begin
                state <= S_START;
                idx   <= '0;
              end else begin
                st_fail <= 1'b1;
              end
            end
          end
          3'd3: cmd_r  <= reg_wdata;
          3'd4: addr_r <= reg_wdata;
          3'd5: dat0   <= reg_wdata;
          3'd6: dat1   <= reg_wdata;
          3'd7: begin
            blk_mem[bptr] <= reg_wdata;
            bptr          <= bptr + PW'(1);
          end
          default: ;
        endcase
      end
      if (busy && be_done) begin
        if (be_arb_lost) begin
          st_col  <= 1'b1;
          nr_pend <= 1'b0;
          state   <= S_IDLE;
        end else if (be_op == OP_WRITE && !be_ack) begin
          nr_pend <= 1'b1;
          state   <= S_STOP;
        end else begin
          case (state)
            S_START: state <= S_ADDR;
            S_ADDR: begin
              idx <= '0;
              if (proto == PR_QUICK)               state <= S_STOP;
              else if (proto == PR_BYTE && rd)     state <= S_RDATA;
              else                                 state <= S_CMD;
            end
            S_CMD: begin
              idx <= '0;
              if (proto == PR_BYTE) state <= S_STOP;
              else if (rd)          state <= S_RSTART;
              else                  state <= S_WDATA;
            end
            S_RSTART: state <= S_RADDR;
            S_RADDR: begin
              idx   <= '0;
              state <= S_RDATA;
            end
            S_WDATA: begin
              if (last) state <= S_STOP;
              else      idx   <= idx + CW'(1);
            end
            S_RDATA: begin
              if (is_blk && idx == '0) begin
                dat0 <= 8'(rx_cnt);
                if (rx_cnt == '0) state <= S_STOP;
                else              idx   <= CW'(1);
              end else begin
                if (is_blk)             blk_mem[bidx] <= be_rx;
                else if (idx == '0)     dat0 <= be_rx;
                else                    dat1 <= be_rx;
                if (last) state <= S_STOP;
                else      idx   <= idx + CW'(1);
              end
            end
            S_STOP: begin
              state   <= S_IDLE;
              nr_pend <= 1'b0;
              if (nr_pend) st_nr   <= 1'b1;
              else         st_done <= 1'b1;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       irq,
  input logic       be_req,
  input logic [1:0] be_op,
  input logic [7:0] be_tx,
  input logic       be_nack,
  input logic       be_done,
  input logic       be_ack,
  input logic       be_arb_lost
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !be_req && !irq);

  p_go_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_req) |-> $past(reg_wr) && $past(reg_addr) == 3'd2 && $past(reg_wdata[6]));

  p_first_op_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_req) |-> be_op == 2'd0);

  p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_done |=> be_req && $stable(be_op) && $stable(be_tx));

  p_nack_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    be_nack |-> be_op == 2'd2);

  p_stop_after_noack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_done && be_op == 2'd1 && !be_ack && !be_arb_lost |=> be_req && be_op == 2'd3);

  p_arb_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_done && be_arb_lost |=> !be_req);

  p_stop_ends_r13: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_done && be_op == 2'd3 |=> !be_req);
endmodule

bind smbus_host smbus_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .irq(irq), .be_req(be_req), .be_op(be_op), .be_tx(be_tx), .be_nack(be_nack),
  .be_done(be_done), .be_ack(be_ack), .be_arb_lost(be_arb_lost)
);

// File: tb/smbus_host_test.sv
module smbus_host_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, be_req, be_nack;
  logic [1:0] be_op;
  logic [7:0] be_tx;
  logic       be_done = 1'b0, be_ack = 1'b1, be_arb_lost = 1'b0;
  logic [7:0] be_rx = '0;

  smbus_host uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  int lat = 2, nack_at = -1, arb_at = -1;
  logic [7:0] rxq [64];
  logic [7:0] wbuf [32];
  logic [1:0] log_op [64];
  logic [7:0] log_tx [64];
  logic       log_nk [64];
  int nops = 0, rxi = 0, cnt = 0;
  logic [1:0] cur_op = '0;
  logic log_clr = 1'b0;

  always @(posedge clk) begin
    be_done <= 1'b0;
    if (log_clr) begin
      nops = 0; rxi = 0; cnt = 0;
    end else if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        be_done     <= 1'b1;
        be_ack      <= (nops - 1) != nack_at;
        be_arb_lost <= (nops - 1) == arb_at;
        if (cur_op == 2'd2) begin
          be_rx <= rxq[rxi];
          rxi = rxi + 1;
        end
      end
    end else if (be_req && !be_done) begin
      cur_op = be_op;
      if (nops < 64) begin
        log_op[nops] = be_op; log_tx[nops] = be_tx; log_nk[nops] = be_nack;
      end
      nops = nops + 1;
      cnt = lat;
    end
  end

  logic [1:0] exp_op [64];
  logic [7:0] exp_tx [64];
  logic       exp_nk [64];
  int nexp;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] tx, input logic nk);
    exp_op[nexp] = op; exp_tx[nexp] = tx; exp_nk[nexp] = nk; nexp++;
  endtask

  task automatic build_exp(input logic [2:0] pr, input logic rw, input logic [6:0] a7,
                           input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1);
    int c;
    logic two;
    nexp = 0;
    two = rw && pr != 3'd0 && pr != 3'd1;
    push(2'd0, 8'h00, 1'b0);
    push(2'd1, {a7, two ? 1'b0 : rw}, 1'b0);
    if (pr == 3'd1) begin
      if (rw) push(2'd2, 8'h00, 1'b1);
      else    push(2'd1, cmd, 1'b0);
    end else if (pr != 3'd0) begin
      push(2'd1, cmd, 1'b0);
      if (!rw) begin
        if (pr == 3'd2 || pr == 3'd3) push(2'd1, d0, 1'b0);
        if (pr == 3'd3) push(2'd1, d1, 1'b0);
        if (pr == 3'd5) begin
          c = (d0 > 32) ? 32 : int'(d0);
          push(2'd1, 8'(c), 1'b0);
          for (int i = 0; i < c; i++) push(2'd1, wbuf[i], 1'b0);
        end
      end else begin
        push(2'd0, 8'h00, 1'b0);
        push(2'd1, {a7, 1'b1}, 1'b0);
        if (pr == 3'd2) push(2'd2, 8'h00, 1'b1);
        if (pr == 3'd3) begin
          push(2'd2, 8'h00, 1'b0);
          push(2'd2, 8'h00, 1'b1);
        end
        if (pr == 3'd5) begin
          c = (rxq[0] > 32) ? 32 : int'(rxq[0]);
          push(2'd2, 8'h00, 1'b0);
          for (int i = 0; i < c; i++) push(2'd2, 8'h00, i == c - 1);
        end
      end
    end
    push(2'd3, 8'h00, 1'b0);
  endtask

  task automatic seq_check(input string tag);
    int bad;
    bad = (nops != nexp) ? 1 : 0;
    for (int i = 0; i < nexp && i < nops && bad == 0; i++) begin
      if (log_op[i] != exp_op[i]) bad = 1;
      else if (exp_op[i] == 2'd1 && log_tx[i] != exp_tx[i]) bad = 1;
      else if (exp_op[i] == 2'd2 && log_nk[i] != exp_nk[i]) bad = 1;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: operation sequence differs, actual %0d ops expected %0d ops", tag, nops, nexp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, s);
      if (!s[0]) break;
    end
    if (s[0]) begin
      fails++; checks++;
      $display("FAIL %s: still busy, actual 1 expected 0", tag);
    end
  endtask

  localparam logic [50:0] VEC [8] = '{
    {3'd0, 1'b0, 7'h2A, 8'h11, 8'h21, 8'h31, 8'h41, 8'h51},
    {3'd0, 1'b1, 7'h15, 8'h12, 8'h22, 8'h32, 8'h42, 8'h52},
    {3'd1, 1'b0, 7'h33, 8'hA5, 8'h23, 8'h33, 8'h43, 8'h53},
    {3'd1, 1'b1, 7'h34, 8'h14, 8'h24, 8'h34, 8'h9C, 8'h54},
    {3'd2, 1'b0, 7'h48, 8'h15, 8'h7E, 8'h35, 8'h45, 8'h55},
    {3'd2, 1'b1, 7'h49, 8'h16, 8'h26, 8'h36, 8'hC3, 8'h56},
    {3'd3, 1'b0, 7'h50, 8'h17, 8'h34, 8'h12, 8'h47, 8'h57},
    {3'd3, 1'b1, 7'h51, 8'h18, 8'h28, 8'h38, 8'hEF, 8'hBE}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 64; i++) rxq[i] = '0;
    for (int i = 0; i < 32; i++) wbuf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", irq, 0);
    chk("R1 be_req", be_req, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register", v, 0);
    end

    // Table walk: R3..R6, R13
    for (int n = 0; n < 8; n++) begin
      logic [2:0] pr; logic rw; logic [6:0] a7; logic [7:0] cm, d0, d1, r0, r1;
      {pr, rw, a7, cm, d0, d1, r0, r1} = VEC[n];
      rxq[0] = r0; rxq[1] = r1;
      nack_at = -1; arb_at = -1;
      wr(3'd4, {a7, rw}); wr(3'd3, cm); wr(3'd5, d0); wr(3'd6, d1);
      clear_log();
      wr(3'd2, 8'h40 | {3'b0, pr, 2'b0});
      wait_idle("R2 table");
      build_exp(pr, rw, a7, cm, d0, d1);
      seq_check("R3 R4 R5 R6 table sequence");
      rd(3'd0, v); chk("R13 success status", v, 8'h02);
      rd(3'd5, v); chk("R4 R6 data0", v, (rw && pr != 3'd0) ? r0 : d0);
      rd(3'd6, v); chk("R6 data1", v, (rw && pr == 3'd3) ? r1 : d1);
      wr(3'd0, 8'h1E);
      rd(3'd0, v); chk("R13 cleared", v, 8'h00);
    end

    // R7/R9: block write of three bytes
    rd(3'd2, v);
    wr(3'd7, 8'hAA); wr(3'd7, 8'hBB); wr(3'd7, 8'hCC);
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    wr(3'd4, {7'h50, 1'b0}); wr(3'd3, 8'h6D); wr(3'd5, 8'd3);
    clear_log();
    wr(3'd2, 8'h54);
    wait_idle("R7 block write");
    build_exp(3'd5, 1'b0, 7'h50, 8'h6D, 8'd3, 8'h00);
    seq_check("R7 block write sequence");
    wr(3'd0, 8'h1E);

    // R7: count clamp
    wr(3'd5, 8'd40);
    clear_log();
    wr(3'd2, 8'h54);
    wait_idle("R7 clamp");
    build_exp(3'd5, 1'b0, 7'h50, 8'h6D, 8'd40, 8'h00);
    seq_check("R7 clamped block write sequence");
    chk("R7 count byte", log_tx[3], 8'h20);
    wr(3'd0, 8'h1E);

    // R8/R9: block read of two bytes
    rxq[0] = 8'd2; rxq[1] = 8'h11; rxq[2] = 8'h22;
    wr(3'd4, {7'h50, 1'b1});
    clear_log();
    wr(3'd2, 8'h54);
    wait_idle("R8 block read");
    build_exp(3'd5, 1'b1, 7'h50, 8'h6D, 8'd0, 8'h00);
    seq_check("R8 block read sequence");
    rd(3'd5, v); chk("R8 count in data0", v, 8'd2);
    rd(3'd2, v);
    rd(3'd7, v); chk("R9 port entry0", v, 8'h11);
    rd(3'd7, v); chk("R9 port entry1", v, 8'h22);
    rd(3'd7, v); chk("R9 port entry2", v, 8'hCC);
    rd(3'd2, v);
    rd(3'd7, v); chk("R9 pointer rewind", v, 8'h11);
    wr(3'd0, 8'h1E);

    // R8: zero count
    rxq[0] = 8'd0;
    clear_log();
    wr(3'd2, 8'h54);
    wait_idle("R8 zero");
    build_exp(3'd5, 1'b1, 7'h50, 8'h6D, 8'd0, 8'h00);
    seq_check("R8 zero-count sequence");
    rd(3'd5, v); chk("R8 zero count", v, 8'd0);
    wr(3'd0, 8'h1E);

    // R8: count clamp on read
    rxq[0] = 8'd50;
    for (int i = 1; i < 40; i++) rxq[i] = 8'(i);
    clear_log();
    wr(3'd2, 8'h54);
    wait_idle("R8 clamp");
    build_exp(3'd5, 1'b1, 7'h50, 8'h6D, 8'd0, 8'h00);
    seq_check("R8 clamped block read sequence");
    rd(3'd5, v); chk("R8 clamped count", v, 8'd32);
    rd(3'd2, v);
    rd(3'd7, v); chk("R8 first buffer byte", v, 8'd1);
    wr(3'd0, 8'h1E);

    // R10/R14: no ACK on address, interrupt enabled
    wr(3'd4, {7'h22, 1'b0}); wr(3'd5, 8'h5A);
    nack_at = 1;
    clear_log();
    wr(3'd2, 8'h49);
    wait_idle("R10 addr");
    chk("R10 op count", nops, 3);
    chk("R10 stop follows", log_op[2], 2'd3);
    rd(3'd0, v); chk("R10 no-response status", v, 8'h04);
    chk("R14 irq raised", irq, 1);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R13 zero write keeps", v, 8'h04);
    wr(3'd0, 8'h04);
    #1 chk("R14 irq dropped", irq, 0);

    // R10: no ACK on first data byte of a word write
    nack_at = 3;
    clear_log();
    wr(3'd2, 8'h4C);
    wait_idle("R10 data");
    chk("R10 ops after data nack", nops, 5);
    chk("R10 last op stop", log_op[4], 2'd3);
    rd(3'd0, v); chk("R10 status data nack", v, 8'h04);
    wr(3'd0, 8'h1E);
    nack_at = -1;

    // R11: arbitration lost on command byte
    arb_at = 2;
    clear_log();
    wr(3'd2, 8'h4C);
    wait_idle("R11");
    chk("R11 ops", nops, 3);
    rd(3'd0, v); chk("R11 collision status", v, 8'h08);
    wr(3'd0, 8'h1E);
    arb_at = -1;

    // R12: invalid protocol
    clear_log();
    wr(3'd2, 8'h50);
    repeat (10) @(negedge clk);
    chk("R12 no ops", nops, 0);
    rd(3'd0, v); chk("R12 failed status", v, 8'h10);
    wr(3'd0, 8'h1E);

    // R2: writes ignored while busy
    lat = 6;
    wr(3'd4, {7'h2B, 1'b0}); wr(3'd3, 8'h44); wr(3'd5, 8'h55); wr(3'd6, 8'h66);
    clear_log();
    wr(3'd2, 8'h4C);
    rd(3'd0, v); chk("R2 busy set", v[0], 1);
    wr(3'd5, 8'h99);
    wr(3'd2, 8'h44);
    wait_idle("R2 busy");
    build_exp(3'd3, 1'b0, 7'h2B, 8'h44, 8'h55, 8'h66);
    seq_check("R2 sequence unaffected");
    rd(3'd5, v); chk("R2 data0 kept", v, 8'h55);
    rd(3'd2, v); chk("R2 control kept", v, 8'h0C);
    wr(3'd0, 8'h1E);
    lat = 2;

    // R13: clear in the same cycle as completion
    clear_log();
    wr(3'd2, 8'h48);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (be_done && be_op == 2'd3) break;
    end
    reg_addr = 3'd0; reg_wdata = 8'h1E; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd0, v); chk("R13 set beats clear", v, 8'h02);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule